// File: doc/BRIEF.md
# Opcode Fetch Supervisor

The block sits beside an 8-bit processor and watches every bus cycle it completes. When the processor fetches an opcode (sync high on a read), the fetched byte is classified through a 256-entry constant table that marks it invalid, one-byte or read-modify-write. An invalid byte never reaches the processor. The block puts the break opcode 0x00 on the processor's data input in its place, asks the clock generator to hold the clock, and records the offending byte and its address in a fault register.

The block also tells the clock generator which bus cycles need no memory. These are the dummy read after a one-byte instruction, during which it asks for a prefetch of the next opcode, and the first write of a read-modify-write instruction. It recognises interrupt entry because the program counter did not advance after an opcode fetch. It keeps the user/supervisor bit outside the processor. It also treats return-from-interrupt as a two-byte instruction whose second byte carries mapping flags for the memory-mapping logic.

One bus cycle completes on each clock in which `cyc_vld` is high. Sync, read/write, address and data are valid during that clock.

Top module: `opfetch_supervisor`

## Requirements
- R1: Opcode classes follow the 8-bit opcode fields aaa=[7:5], bbb=[4:2], cc=[1:0]. Every cc=11 byte and 0x89 are invalid, for example, while 0x00, 0x40 and 0xA9 are valid. A valid fetched byte passes unchanged to `cpu_data`, and `clk_hold` stays low.
- R2: While an invalid opcode is being fetched (sync and rw high), `cpu_data` is 0x00 and `clk_hold` is high in that same cycle.
- R3: The first invalid fetch is latched into `fault_vld`/`fault_opc`/`fault_addr` on its completing edge. Later faults do not overwrite it. `fault_clr` clears it. A fault completing in the same cycle as `fault_clr` is latched.
- R4: After a completed fetch of a one-byte opcode at address A, `mem_skip` and `pf_req` are high until the next completed cycle, with `pf_addr` = A+1.
- R5: After a read-modify-write opcode fetch, `mem_skip` is high during the first write cycle only. Earlier reads and the final write show it low.
- R6: After a valid fetch at A, the checked cycle must address A+1. For a one-byte opcode the checked cycle is the second cycle after the fetch, because the dummy cycle is excluded. Otherwise it is the next cycle. A mismatch makes `irq_entry` high for exactly one clock and sets `sup_mode`.
- R7: After a fetch of 0x40, a following read of A+1 loads that byte into `map_flags`. If its bit 0 is 1, `sup_mode` drops to user (0). Otherwise the mode is unchanged.
- R8: After reset, `sup_mode`=1, and `fault_vld`, `mem_skip`, `pf_req`, `irq_entry` and `map_flags` are 0.
- R9: A completed invalid fetch sets `sup_mode` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_vld | input | 1 | A bus cycle completes on this clock |
| sync | input | 1 | Current cycle is an opcode fetch |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Bus address |
| mem_data | input | 8 | Byte read from memory |
| fault_clr | input | 1 | Clear the fault register |
| cpu_data | output | 8 | Byte presented to the processor |
| clk_hold | output | 1 | Hold the clock: break is being substituted |
| mem_skip | output | 1 | Current cycle needs no memory |
| pf_req | output | 1 | Start a read of the next opcode |
| pf_addr | output | AW | Address for the prefetch |
| sup_mode | output | 1 | 1 = supervisor, 0 = user |
| irq_entry | output | 1 | One-clock pulse on interrupt entry |
| map_flags | output | 8 | Flags from the last extended return |
| fault_vld | output | 1 | Fault register holds an entry |
| fault_opc | output | 8 | Offending opcode |
| fault_addr | output | AW | Address of the offending opcode |

## Verification
A wrong table entry shows at once at `cpu_data` and `clk_hold` during the fetch itself. A stale sequencing state shows one cycle later as a missing or spurious `mem_skip`/`pf_req`, or as a false `irq_entry`. The mode bit cannot be read directly except through `sup_mode`. The bench therefore moves it into user mode with an extended return before each interrupt or fault test, so that a missing set is visible on the next edge. Fault register errors show on the edge after the fault, or after `fault_clr`.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int OPC_W = 8;
  localparam int OPC_N = 1 << OPC_W;
  localparam logic [OPC_W-1:0] BRK_OPC = 8'h00;
  localparam logic [OPC_W-1:0] RTI_OPC = 8'h40;
  localparam logic [OPC_W-1:0] RTS_OPC = 8'h60;
  localparam logic [OPC_W-1:0] STI_OPC = 8'h89;
  localparam int FLAG_USER_BIT = 0;

  // bit 0 invalid, bit 1 one-byte, bit 2 read-modify-write
  typedef struct packed {
    logic rmw;
    logic one_byte;
    logic invalid;
  } opc_class_t;

  typedef enum logic [1:0] {CHK_IDLE, CHK_SKIP, CHK_CMP} chk_st_t;

  function automatic opc_class_t classify(input logic [OPC_W-1:0] op);
    logic [2:0] aaa;
    logic [2:0] bbb;
    logic [1:0] cc;
    logic       ok;
    opc_class_t c;
    aaa = op[7:5];
    bbb = op[4:2];
    cc  = op[1:0];
    ok  = 1'b0;
    case (cc)
      2'b01: ok = (op != STI_OPC);
      2'b10: begin
        case (bbb)
          3'd0:    ok = (aaa == 3'd5);
          3'd4:    ok = 1'b0;
          3'd6:    ok = (aaa == 3'd4) || (aaa == 3'd5);
          3'd7:    ok = (aaa != 3'd4);
          default: ok = 1'b1;
        endcase
      end
      2'b00: begin
        case (bbb)
          3'd0:    ok = (aaa != 3'd4);
          3'd1:    ok = (aaa == 3'd1) || (aaa >= 3'd4);
          3'd3:    ok = (aaa != 3'd0);
          3'd5:    ok = (aaa == 3'd4) || (aaa == 3'd5);
          3'd7:    ok = (aaa == 3'd5);
          default: ok = 1'b1;
        endcase
      end
      default: ok = 1'b0;
    endcase
    c.invalid  = ~ok;
    c.one_byte = ok && (((cc == 2'b00 || cc == 2'b10) && (bbb == 3'd2 || bbb == 3'd6))
                        || (op == RTS_OPC));
    c.rmw      = ok && (cc == 2'b10) && bbb[0] && (aaa != 3'd4) && (aaa != 3'd5);
    return c;
  endfunction
endpackage

// File: rtl/ofs_opc_table.sv
module ofs_opc_table
  import ofs_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output opc_class_t       cls
);
  opc_class_t tbl [OPC_N];

  for (genvar i = 0; i < OPC_N; i++) begin : g_tbl
    assign tbl[i] = classify(OPC_W'(i));
  end

  assign cls = tbl[opc];
endmodule

// File: rtl/ofs_fault_reg.sv
module ofs_fault_reg
  import ofs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic             clr,
  input  logic [OPC_W-1:0] opc_in,
  input  logic [AW-1:0]    addr_in,
  output logic             vld,
  output logic [OPC_W-1:0] opc,
  output logic [AW-1:0]    addr
);
  logic             vld_q, vld_d;
  logic [OPC_W-1:0] opc_q, opc_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic             en;

  assign en = set | clr;

  always_comb begin
    vld_d  = vld_q;
    opc_d  = opc_q;
    addr_d = addr_q;
    if (set && (!vld_q || clr)) begin
      vld_d  = 1'b1;
      opc_d  = opc_in;
      addr_d = addr_in;
    end else if (clr) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      opc_q  <= '0;
      addr_q <= '0;
    end else if (en) begin
      vld_q  <= vld_d;
      opc_q  <= opc_d;
      addr_q <= addr_d;
    end
  end

  assign vld  = vld_q;
  assign opc  = opc_q;
  assign addr = addr_q;
endmodule

// File: rtl/ofs_seq.sv
module ofs_seq
  import ofs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_vld,
  input  logic             sync,
  input  logic             rw,
  input  logic [AW-1:0]    addr,
  input  logic [OPC_W-1:0] mem_data,
  input  opc_class_t       cls,
  output logic             mem_skip,
  output logic             pf_req,
  output logic [AW-1:0]    pf_addr,
  output logic             sup_mode,
  output logic             irq_entry,
  output logic [OPC_W-1:0] map_flags
);
  chk_st_t          chk_q, chk_d;
  logic [AW-1:0]    exp_q, exp_d;
  logic             rti_q, rti_d;
  logic             dummy_q, dummy_d;
  logic [AW-1:0]    pf_q, pf_d;
  logic             rmw_q, rmw_d;
  logic             sup_q, sup_d;
  logic             irq_q, irq_d;
  logic [OPC_W-1:0] flg_q, flg_d;
  logic             fetch;
  logic             detect;
  logic [AW-1:0]    next_addr;

  assign fetch     = cyc_vld & sync & rw;
  assign next_addr = addr + AW'(1);

  always_comb begin
    chk_d   = chk_q;
    exp_d   = exp_q;
    rti_d   = rti_q;
    dummy_d = dummy_q;
    pf_d    = pf_q;
    rmw_d   = rmw_q;
    sup_d   = sup_q;
    flg_d   = flg_q;
    irq_d   = 1'b0;
    detect  = 1'b0;
    if (cyc_vld) begin
      dummy_d = 1'b0;
      if (!rw) rmw_d = 1'b0;
      case (chk_q)
        CHK_SKIP: chk_d = CHK_CMP;
        CHK_CMP: begin
          chk_d = CHK_IDLE;
          rti_d = 1'b0;
          if (addr != exp_q) begin
            detect = 1'b1;
          end else if (rti_q && rw) begin
            flg_d = mem_data;
            if (mem_data[FLAG_USER_BIT]) sup_d = 1'b0;
          end
        end
        default: chk_d = chk_q;
      endcase
      if (detect) begin
        sup_d = 1'b1;
        irq_d = 1'b1;
      end
      if (fetch) begin
        rmw_d = 1'b0;
        if (cls.invalid) begin
          sup_d = 1'b1;
          chk_d = CHK_IDLE;
          rti_d = 1'b0;
        end else begin
          chk_d   = cls.one_byte ? CHK_SKIP : CHK_CMP;
          exp_d   = next_addr;
          rti_d   = (mem_data == RTI_OPC);
          dummy_d = cls.one_byte;
          pf_d    = next_addr;
          rmw_d   = cls.rmw;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q   <= CHK_IDLE;
      exp_q   <= '0;
      rti_q   <= 1'b0;
      dummy_q <= 1'b0;
      pf_q    <= '0;
      rmw_q   <= 1'b0;
      sup_q   <= 1'b1;
      flg_q   <= '0;
    end else if (cyc_vld) begin
      chk_q   <= chk_d;
      exp_q   <= exp_d;
      rti_q   <= rti_d;
      dummy_q <= dummy_d;
      pf_q    <= pf_d;
      rmw_q   <= rmw_d;
      sup_q   <= sup_d;
      flg_q   <= flg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign mem_skip  = dummy_q | (rmw_q & ~rw);
  assign pf_req    = dummy_q;
  assign pf_addr   = pf_q;
  assign sup_mode  = sup_q;
  assign irq_entry = irq_q;
  assign map_flags = flg_q;
endmodule

// File: rtl/opfetch_supervisor.sv
module opfetch_supervisor
  import ofs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_vld,
  input  logic             sync,
  input  logic             rw,
  input  logic [AW-1:0]    addr,
  input  logic [OPC_W-1:0] mem_data,
  input  logic             fault_clr,
  output logic [OPC_W-1:0] cpu_data,
  output logic             clk_hold,
  output logic             mem_skip,
  output logic             pf_req,
  output logic [AW-1:0]    pf_addr,
  output logic             sup_mode,
  output logic             irq_entry,
  output logic [OPC_W-1:0] map_flags,
  output logic             fault_vld,
  output logic [OPC_W-1:0] fault_opc,
  output logic [AW-1:0]    fault_addr
);
  logic       rst_s1, rst_s2;
  opc_class_t cls;
  logic       subst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  ofs_opc_table u_tbl (
    .opc (mem_data),
    .cls (cls)
  );

  assign subst    = sync & rw & cls.invalid;
  assign cpu_data = subst ? BRK_OPC : mem_data;
  assign clk_hold = subst;

  ofs_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s2),
    .cyc_vld   (cyc_vld),
    .sync      (sync),
    .rw        (rw),
    .addr      (addr),
    .mem_data  (mem_data),
    .cls       (cls),
    .mem_skip  (mem_skip),
    .pf_req    (pf_req),
    .pf_addr   (pf_addr),
    .sup_mode  (sup_mode),
    .irq_entry (irq_entry),
    .map_flags (map_flags)
  );

  ofs_fault_reg #(.AW(AW)) u_fault (
    .clk     (clk),
    .rst_n   (rst_s2),
    .set     (cyc_vld & subst),
    .clr     (fault_clr),
    .opc_in  (mem_data),
    .addr_in (addr),
    .vld     (fault_vld),
    .opc     (fault_opc),
    .addr    (fault_addr)
  );
endmodule

// File: rtl/opfetch_supervisor_chk.sv
module opfetch_supervisor_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_vld,
  input logic          sync,
  input logic          rw,
  input logic          fault_clr,
  input logic [7:0]    cpu_data,
  input logic          clk_hold,
  input logic          mem_skip,
  input logic          pf_req,
  input logic          sup_mode,
  input logic          irq_entry,
  input logic          fault_vld,
  input logic [7:0]    fault_opc,
  input logic [AW-1:0] fault_addr
);
  AST_SUBST_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    clk_hold |-> (cpu_data == 8'h00)); // R2
  AST_HOLD_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    clk_hold |-> (sync && rw)); // R2
  AST_FAULT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vld && !fault_clr) |=> (fault_vld && $stable(fault_opc) && $stable(fault_addr))); // R3
  AST_PREFETCH_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req |-> mem_skip); // R4
  AST_IRQ_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |-> sup_mode); // R6
  AST_FAULT_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_vld && clk_hold) |=> sup_mode); // R9
endmodule

bind opfetch_supervisor opfetch_supervisor_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_vld    (cyc_vld),
  .sync       (sync),
  .rw         (rw),
  .fault_clr  (fault_clr),
  .cpu_data   (cpu_data),
  .clk_hold   (clk_hold),
  .mem_skip   (mem_skip),
  .pf_req     (pf_req),
  .sup_mode   (sup_mode),
  .irq_entry  (irq_entry),
  .fault_vld  (fault_vld),
  .fault_opc  (fault_opc),
  .fault_addr (fault_addr)
);

// File: tb/opfetch_supervisor_tb.sv
module opfetch_supervisor_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cyc_vld, sync, rw, fault_clr;
  logic [AW-1:0] addr;
  logic [7:0]    mem_data;
  logic [7:0]    cpu_data, map_flags, fault_opc;
  logic          clk_hold, mem_skip, pf_req, sup_mode, irq_entry, fault_vld;
  logic [AW-1:0] pf_addr, fault_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opfetch_supervisor #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .sync(sync), .rw(rw),
    .addr(addr), .mem_data(mem_data), .fault_clr(fault_clr),
    .cpu_data(cpu_data), .clk_hold(clk_hold), .mem_skip(mem_skip),
    .pf_req(pf_req), .pf_addr(pf_addr), .sup_mode(sup_mode),
    .irq_entry(irq_entry), .map_flags(map_flags), .fault_vld(fault_vld),
    .fault_opc(fault_opc), .fault_addr(fault_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic s, input logic r, input logic [AW-1:0] a, input logic [7:0] d);
    cyc_vld  = 1'b1;
    sync     = s;
    rw       = r;
    addr     = a;
    mem_data = d;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc_vld   = 1'b0;
    sync      = 1'b0;
    rw        = 1'b1;
    fault_clr = 1'b0;
  endtask

  task automatic go_user();
    bus(1'b1, 1'b1, 16'h4000, 8'h40); tick();
    bus(1'b0, 1'b1, 16'h4001, 8'h01); tick();
  endtask

  task automatic t_reset();
    check("R8 sup_mode", sup_mode, 1);
    check("R8 fault_vld", fault_vld, 0);
    check("R8 mem_skip", mem_skip, 0);
    check("R8 pf_req", pf_req, 0);
    check("R8 irq_entry", irq_entry, 0);
    check("R8 map_flags", map_flags, 0);
  endtask

  task automatic t_valid_pass();
    bus(1'b1, 1'b1, 16'h1000, 8'hA9);
    check("R1 cpu_data A9", cpu_data, 8'hA9);
    check("R1 clk_hold A9", clk_hold, 0);
    tick();
    bus(1'b0, 1'b1, 16'h1001, 8'h05);
    check("R4 no skip after two-byte", mem_skip, 0);
    tick();
    check("R6 no irq on A+1", irq_entry, 0);
    bus(1'b1, 1'b1, 16'h1002, 8'h00);
    check("R1 native break passes", cpu_data, 8'h00);
    check("R1 native break no hold", clk_hold, 0);
    tick();
    bus(1'b0, 1'b1, 16'h1003, 8'h00); tick();
  endtask

  task automatic t_one_byte();
    bus(1'b1, 1'b1, 16'h2000, 8'hE8); tick();
    check("R4 mem_skip dummy", mem_skip, 1);
    check("R4 pf_req", pf_req, 1);
    check("R4 pf_addr", pf_addr, 16'h2001);
    bus(1'b0, 1'b1, 16'h2001, 8'hA9); tick();
    check("R4 skip ends", mem_skip, 0);
    check("R4 pf_req ends", pf_req, 0);
    bus(1'b1, 1'b1, 16'h2001, 8'hA9); tick();
    check("R6 no irq after one-byte", irq_entry, 0);
    bus(1'b0, 1'b1, 16'h2002, 8'h11); tick();
  endtask

  task automatic t_rti();
    go_user();
    check("R7 user mode", sup_mode, 0);
    check("R7 map_flags", map_flags, 8'h01);
    bus(1'b1, 1'b1, 16'h4100, 8'h40); tick();
    bus(1'b0, 1'b1, 16'h4101, 8'h80); tick();
    check("R7 flags 80", map_flags, 8'h80);
    check("R7 mode kept", sup_mode, 0);
  endtask

  task automatic t_irq();
    go_user();
    bus(1'b1, 1'b1, 16'h5000, 8'hA9); tick();
    bus(1'b0, 1'b0, 16'h01FD, 8'h00); tick();
    check("R6 irq pulse", irq_entry, 1);
    check("R6 supervisor", sup_mode, 1);
    tick();
    check("R6 pulse one clock", irq_entry, 0);
    go_user();
    bus(1'b1, 1'b1, 16'h7000, 8'h18); tick();
    bus(1'b0, 1'b1, 16'h7000, 8'h18); tick();
    check("R6 dummy excluded", irq_entry, 0);
    bus(1'b0, 1'b0, 16'h01FC, 8'h00); tick();
    check("R6 irq after one-byte", irq_entry, 1);
    check("R6 sup after one-byte", sup_mode, 1);
  endtask

  task automatic t_rmw();
    bus(1'b1, 1'b1, 16'h6000, 8'hEE); tick();
    bus(1'b0, 1'b1, 16'h6001, 8'h34);
    check("R5 operand read", mem_skip, 0); tick();
    bus(1'b0, 1'b1, 16'h6002, 8'h12); tick();
    bus(1'b0, 1'b1, 16'h1234, 8'h7F);
    check("R5 data read", mem_skip, 0); tick();
    bus(1'b0, 1'b0, 16'h1234, 8'h7F);
    check("R5 first write skip", mem_skip, 1); tick();
    bus(1'b0, 1'b0, 16'h1234, 8'h80);
    check("R5 final write", mem_skip, 0); tick();
  endtask

  task automatic t_fault();
    go_user();
    bus(1'b1, 1'b1, 16'h3000, 8'h02);
    check("R2 cpu_data", cpu_data, 8'h00);
    check("R2 clk_hold", clk_hold, 1);
    tick();
    check("R3 fault_vld", fault_vld, 1);
    check("R3 fault_opc", fault_opc, 8'h02);
    check("R3 fault_addr", fault_addr, 16'h3000);
    check("R9 supervisor", sup_mode, 1);
    bus(1'b1, 1'b1, 16'h3100, 8'h89);
    check("R1 0x89 invalid", cpu_data, 8'h00);
    tick();
    check("R3 first kept", fault_opc, 8'h02);
    fault_clr = 1'b1;
    bus(1'b1, 1'b1, 16'h3200, 8'hFF); tick();
    check("R3 set beats clear vld", fault_vld, 1);
    check("R3 set beats clear opc", fault_opc, 8'hFF);
    check("R3 set beats clear addr", fault_addr, 16'h3200);
    fault_clr = 1'b1; tick();
    check("R3 cleared", fault_vld, 0);
  endtask

  initial begin
    rst_n = 1'b0; cyc_vld = 1'b0; sync = 1'b0; rw = 1'b1;
    addr = '0; mem_data = '0; fault_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_valid_pass();
    t_one_byte();
    t_rti();
    t_irq();
    t_rmw();
    t_fault();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule